// File: doc/BRIEF.md
# Daisy-Chained Serial Register Slave

This block is a register-access slave for a four-wire serial control bus made of a clock, an active-low select, a data-in line and a data-out line. A second output hands the incoming stream on to the next device, so that up to sixteen devices hang off one controller in a chain. Each access is a control byte, an address byte and one or two data bytes. The control byte carries a 4-bit channel number, sent least significant bit first. Every device passes that number downstream reduced by one, bit by bit as it flows through. The device that receives a zero executes the access. For a broadcast write, every device in the chain executes it.

The bus pins are oversampled by the system clock. Data is taken on rising serial-clock edges and read data is launched on falling edges. The data-out pin comes with an output enable, so that a pad can release it, or data-in and data-out can share one wire. Behind the serial front end sits a 64 × 8 register file that clears on reset. A select rise that does not fall on a byte boundary returns the framing logic to its idle state, which lets the controller resynchronise.

Top module: `chain_spi_regslave`

## Requirements
- R1: Only rising `sclk` edges seen while `cs_n` is low are sampled, most significant bit first. A frame is a control byte, then an address byte, then data bytes. There is one data byte when `two_data_bytes` is 0 and two when it is 1. After the last data byte the next byte is decoded as a control byte.
- R2: Control byte encoding: bit 7 is ID bit 0, bit 6 is ID bit 1, bit 5 is ID bit 2, bit 4 is ID bit 3, bit 3 is broadcast, and bit 2 is read (1) or write (0). Bits 1:0 must be 2'b10. If they are not, the device neither writes nor drives `miso` for the rest of that frame, and it still forwards the stream.
- R3: A non-broadcast access is executed only by the device whose received ID is 0. An ID beyond the last device in the chain changes no register anywhere.
- R4: `chain_out` repeats `mosi`, except for the four ID bits of each control byte. Those carry the received ID minus one, modulo 16, in the same LSB-first order. The device at chain position k is therefore addressed with ID k.
- R5: A broadcast write is executed by every device, whatever the ID. A broadcast read is ignored by every device, and none of them drives `miso`.
- R6: Bits 5:0 of the address byte select the register, and bits 7:6 are ignored. In two-byte mode the second data byte goes to, or comes from, the address plus one, wrapping modulo 64.
- R7: For a valid read, the addressed device shows the register on `miso`, MSB first. `miso` changes only after falling `sclk` edges with `cs_n` low, and the first bit appears after the first falling edge that follows the address byte. `miso_oe` is high only during the data bytes of such a read.
- R8: If `cs_n` goes high after a number of sampled bits that is not a multiple of eight, the frame is abandoned. No write of a truncated byte takes place, and the next frame decodes from its control byte.
- R9: `cs_n` may go high at a byte boundary and `sclk` may keep toggling meanwhile. This does not disturb the frame, which continues at the next byte once `cs_n` is low again.
- R10: After reset every register reads 0 and `miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus pins |
| rst_n | input | 1 | Synchronous active-low reset |
| two_data_bytes | input | 1 | Static mode: 0 gives one data byte per frame, 1 gives two |
| sclk | input | 1 | Serial bus clock, idles high |
| cs_n | input | 1 | Active-low bus select |
| mosi | input | 1 | Serial data from the controller or the upstream device |
| miso | output | 1 | Serial read data |
| miso_oe | output | 1 | Output enable for `miso`; low means the pin is released |
| chain_out | output | 1 | Forwarded stream with rewritten ID for the downstream device |

## Verification
A wrong borrow state in the ID rewrite shows on `chain_out` inside the ID bits of that same control byte. The fault becomes visible at the next device one serial bit later. A framing counter that is out of step shows at the latest in the next frame: a read then returns data from the wrong device or register, or `miso_oe` rises outside a data byte. A corrupted read shifter shows on `miso` within the eight falling edges of the byte it belongs to. A lost or misdirected write stays hidden until that register is read back, so every write in the bench is followed by reads from each chain position.

// File: rtl/chain_spi_pkg.sv
// Shared types for the daisy-chained serial register slave.
// Assumes byte-wide framing and a 4-bit channel number.
package chain_spi_pkg;
    localparam int BYTE_W = 8;
    localparam int CID_W  = 4;

    typedef enum logic [1:0] {PH_CTRL, PH_ADDR, PH_DATA0, PH_DATA1} phase_e;

    typedef struct packed {
        logic [CID_W-1:0] cid;
        logic             bcast;
        logic             rd;
        logic [1:0]       tag;
    } ctrl_s;

    // Split a control byte; the channel number arrives LSB first in bits 7..4.
    function automatic ctrl_s split_ctrl(input logic [BYTE_W-1:0] b);
        ctrl_s c;
        c.cid   = {b[4], b[5], b[6], b[7]};
        c.bcast = b[3];
        c.rd    = b[2];
        c.tag   = b[1:0];
        return c;
    endfunction
endpackage

// File: rtl/spi_edge_sampler.sv
// Oversamples the bus pins with the system clock and reports serial clock
// edges that occur while select is low. Assumes sclk/cs_n/mosi are already
// synchronous to clk or slow enough that one register stage suffices.
module spi_edge_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic rise,
    output logic fall,
    output logic cs_idle,
    output logic din
);
    logic sclk_q, sclk_d, cs_q, din_q;

    // Register the pins and keep one earlier clock sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
            sclk_d <= 1'b1;
            cs_q   <= 1'b1;
            din_q  <= 1'b0;
        end else begin
            sclk_q <= sclk;
            sclk_d <= sclk_q;
            cs_q   <= cs_n;
            din_q  <= mosi;
        end
    end

    assign rise    = sclk_q & ~sclk_d & ~cs_q;
    assign fall    = ~sclk_q & sclk_d & ~cs_q;
    assign cs_idle = cs_q;
    assign din     = din_q;
endmodule

// File: rtl/spi_frame_ctl.sv
// Byte framing and frame decode: counts sampled bits, assembles bytes, walks
// control -> address -> data phases and latches hit/read/address.
// Assumes two_bytes is static for the duration of a frame.
module spi_frame_ctl
    import chain_spi_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise,
    input  logic              cs_idle,
    input  logic              din,
    input  logic              two_bytes,
    output phase_e            phase,
    output logic [2:0]        bit_idx,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              hit,
    output logic              rd_op,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

    logic [BYTE_W-2:0] shreg;
    ctrl_s             ctl;

    assign byte_val  = {shreg, din};
    assign byte_done = rise & (bit_idx == LAST_BIT);
    assign ctl       = split_ctrl(byte_val);

    // Advance the bit counter and phase; abandon a frame cut mid-byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_CTRL;
            bit_idx <= '0;
            shreg   <= '0;
            hit     <= 1'b0;
            rd_op   <= 1'b0;
            addr    <= '0;
        end else if (cs_idle && bit_idx != 3'd0) begin
            phase   <= PH_CTRL;
            bit_idx <= '0;
            hit     <= 1'b0;
            rd_op   <= 1'b0;
        end else if (rise) begin
            shreg   <= byte_val[BYTE_W-2:0];
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == LAST_BIT) begin
                unique case (phase)
                    PH_CTRL: begin
                        hit   <= (ctl.tag == 2'b10) &&
                                 (ctl.bcast ? !ctl.rd : (ctl.cid == '0));
                        rd_op <= ctl.rd & ~ctl.bcast;
                        phase <= PH_ADDR;
                    end
                    PH_ADDR: begin
                        addr  <= byte_val[ADDR_W-1:0];
                        phase <= PH_DATA0;
                    end
                    PH_DATA0: phase <= two_bytes ? PH_DATA1 : PH_CTRL;
                    default:  phase <= PH_CTRL;
                endcase
            end
        end
    end

    // R8: a select rise mid-byte returns framing to the start of a control byte
    a_r8_resync_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_idle && bit_idx != 3'd0) |=> (bit_idx == 3'd0 && phase == PH_CTRL && !hit));
    // R1: the second data byte always closes the frame
    a_r1_frame_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_DATA1) |=> (phase == PH_CTRL));
    // R2: a control byte with a bad tag never selects the device
    a_r2_bad_tag_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_CTRL && byte_val[1:0] != 2'b10) |=> !hit);
endmodule

// File: rtl/spi_chain_fwd.sv
// Forwards the incoming stream to the next device and subtracts one from the
// LSB-first channel number on the fly with a serial borrow.
// Assumes the ID occupies the first CID_W bits of each control byte.
module spi_chain_fwd
    import chain_spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    input  logic       cs_idle,
    input  phase_e     phase,
    input  logic [2:0] bit_idx,
    input  logic       din,
    output logic       chain_out
);
    logic borrow, borrow_eff, in_id;

    assign in_id      = ~cs_idle & (phase == PH_CTRL) & (bit_idx < 3'(CID_W));
    assign borrow_eff = (bit_idx == 3'd0) ? 1'b1 : borrow;

    // Drive the forwarded bit and carry the borrow to the next ID bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            borrow    <= 1'b1;
            chain_out <= 1'b0;
        end else begin
            chain_out <= din ^ (in_id & borrow_eff);
            if (rise && in_id) borrow <= borrow_eff & ~din;
        end
    end

    // R4: outside the control byte the stream passes through unchanged
    a_r4_copy_outside_id: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_CTRL) |=> (chain_out == $past(din)));
endmodule

// File: rtl/spi_reg_bank.sv
// Register file with one synchronous write port and one combinational read
// port; clears to zero on reset. Assumes at most one write per clock.
module spi_reg_bank #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear every entry on reset, otherwise store the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R6: a write lands at the decoded address
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/chain_spi_regslave.sv
// Top of the daisy-chained serial register slave: edge sampling, framing,
// ID-rewriting pass-through, register file and read shifter.
// Assumes the serial half-period exceeds 2*(chain position)+3 clk cycles.
module chain_spi_regslave
    import chain_spi_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic two_data_bytes,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic miso,
    output logic miso_oe,
    output logic chain_out
);
    logic              rise, fall, cs_idle, din;
    phase_e            phase;
    logic [2:0]        bit_idx;
    logic              byte_done, hit, rd_op;
    logic [BYTE_W-1:0] byte_val, rdata, tx;
    logic [ADDR_W-1:0] addr, addr_nx, waddr, raddr;
    logic              in_data, we, ld, drive;

    spi_edge_sampler u_pins (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .rise(rise), .fall(fall), .cs_idle(cs_idle), .din(din)
    );

    spi_frame_ctl #(.ADDR_W(ADDR_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .rise(rise), .cs_idle(cs_idle), .din(din),
        .two_bytes(two_data_bytes), .phase(phase), .bit_idx(bit_idx),
        .byte_done(byte_done), .byte_val(byte_val), .hit(hit),
        .rd_op(rd_op), .addr(addr)
    );

    spi_chain_fwd u_fwd (
        .clk(clk), .rst_n(rst_n), .rise(rise), .cs_idle(cs_idle),
        .phase(phase), .bit_idx(bit_idx), .din(din), .chain_out(chain_out)
    );

    assign addr_nx = addr + ADDR_W'(1);
    assign in_data = (phase == PH_DATA0) || (phase == PH_DATA1);
    assign we      = byte_done & hit & ~rd_op & in_data;
    assign waddr   = (phase == PH_DATA1) ? addr_nx : addr;
    assign ld      = byte_done & hit & rd_op &
                     ((phase == PH_ADDR) || (phase == PH_DATA0 && two_data_bytes));
    assign raddr   = (phase == PH_ADDR) ? byte_val[ADDR_W-1:0] : addr_nx;
    assign drive   = hit & rd_op & in_data & ~cs_idle;

    spi_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(byte_val),
        .raddr(raddr), .rdata(rdata)
    );

    // Load read data at a byte end and shift it out on falling serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx   <= '0;
            miso <= 1'b0;
        end else if (ld) begin
            tx <= rdata;
        end else if (fall && drive) begin
            miso <= tx[BYTE_W-1];
            tx   <= {tx[BYTE_W-2:0], 1'b0};
        end
    end

    assign miso_oe = drive;

    // R7: read data only moves right after a falling serial edge
    a_r7_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fall) |-> $stable(miso));
    // R5: the pin is never driven while a write frame is in its data bytes
    a_r5_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_data && !rd_op) |-> !miso_oe);
endmodule

// File: tb/chain_spi_regslave_tb.sv
// Scoreboard bench: three chained devices; frame tasks push expected read
// bytes into a queue and a monitor process pops and compares them.
module chain_spi_regslave_tb;
    localparam int H = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0, sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0, two_bytes = 1'b0;
    logic [2:0] link, so, soe;
    logic       bus;

    chain_spi_regslave u_dut (.clk(clk), .rst_n(rst_n), .two_data_bytes(two_bytes),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(so[0]), .miso_oe(soe[0]), .chain_out(link[0]));
    chain_spi_regslave u_dev1 (.clk(clk), .rst_n(rst_n), .two_data_bytes(two_bytes),
        .sclk(sclk), .cs_n(cs_n), .mosi(link[0]), .miso(so[1]), .miso_oe(soe[1]), .chain_out(link[1]));
    chain_spi_regslave u_dev2 (.clk(clk), .rst_n(rst_n), .two_data_bytes(two_bytes),
        .sclk(sclk), .cs_n(cs_n), .mosi(link[1]), .miso(so[2]), .miso_oe(soe[2]), .chain_out(link[2]));

    assign bus = |(so & soe);

    int          n_chk = 0, n_fail = 0;
    logic [7:0]  model [3][64];
    logic [7:0]  exp_val [$];
    string       exp_tag [$];
    event        rx_ev;
    logic [7:0]  rx_byte;
    logic [7:0]  d_cap;
    int          d_fe, d_oe, d_mu;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Monitor: compare each captured read byte with the scoreboard head.
    initial begin
        forever begin
            @(rx_ev);
            if (exp_val.size() == 0) begin
                check(1'b0, "R7", "unexpected read byte", rx_byte, 0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_val.pop_front();
                t = exp_tag.pop_front();
                check(rx_byte == e, t, "read data", rx_byte, e);
            end
        end
    end

    // Shift out the top nbits of b; sample bus and forwarded bit before each rise.
    task automatic send_bits(input logic [7:0] b, input int nbits, input logic [7:0] fwd,
                             output logic [7:0] cap, output int ferr, output int oe_n,
                             output int multi);
        cap = '0; ferr = 0; oe_n = 0; multi = 0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            @(negedge clk);
            sclk = 1'b0;
            mosi = b[i];
            repeat (H - 1) @(negedge clk);
            cap[i] = bus;
            if (link[0] !== fwd[i]) ferr++;
            if (soe != 3'b000) oe_n++;
            if ($countones(soe) > 1) multi++;
            @(negedge clk);
            sclk = 1'b1;
            repeat (H - 1) @(negedge clk);
        end
    endtask

    // Raise select at a byte boundary while the serial clock keeps running.
    task automatic cs_gap();
        @(negedge clk);
        cs_n = 1'b1;
        for (int p = 0; p < 2; p++) begin
            sclk = 1'b0;
            repeat (H) @(negedge clk);
            sclk = 1'b1;
            repeat (H) @(negedge clk);
        end
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic frame(input logic [3:0] id, input logic bc, input logic rw, input logic ok,
                         input logic [7:0] addr, input logic [7:0] d0, input logic [7:0] d1,
                         input bit gap, input string tag);
        logic [7:0] ctrl, fwdc, cap, d;
        logic [3:0] idm;
        logic [5:0] a, a1;
        int         fe, oe, mu, tfe, oe_hdr, oe_dat, tmu, nd;
        bit         resp;
        a    = addr[5:0];
        a1   = a + 6'd1;
        ctrl = {id[0], id[1], id[2], id[3], bc, rw, ok ? 2'b10 : 2'b11};
        idm  = id - 4'd1;
        fwdc = {idm[0], idm[1], idm[2], idm[3], ctrl[3:0]};
        nd   = two_bytes ? 2 : 1;
        resp = ok && rw && !bc && (id < 4'd3);
        if (resp) begin
            exp_val.push_back(model[id][a]);
            exp_tag.push_back(tag);
            if (nd == 2) begin
                exp_val.push_back(model[id][a1]);
                exp_tag.push_back(tag);
            end
        end
        tfe = 0; oe_hdr = 0; oe_dat = 0; tmu = 0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        send_bits(ctrl, 8, fwdc, cap, fe, oe, mu);
        tfe += fe; oe_hdr += oe; tmu += mu;
        if (gap) cs_gap();
        send_bits(addr, 8, addr, cap, fe, oe, mu);
        tfe += fe; oe_hdr += oe; tmu += mu;
        for (int k = 0; k < nd; k++) begin
            if (gap) cs_gap();
            d = rw ? 8'h00 : ((k == 0) ? d0 : d1);
            send_bits(d, 8, d, cap, fe, oe, mu);
            tfe += fe; oe_dat += oe; tmu += mu;
            if (resp || oe > 0) begin
                rx_byte = cap;
                -> rx_ev;
            end
        end
        @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * H) @(negedge clk);
        check(tfe == 0, "R4", "forwarded bits wrong", tfe, 0);
        check(oe_hdr == 0 && tmu == 0, "R7", "miso_oe in header or shared", oe_hdr + tmu, 0);
        if (rw) check((oe_dat > 0) == resp, tag, "miso_oe during data", int'(oe_dat > 0), int'(resp));
        if (ok && !rw) begin
            for (int v = 0; v < 3; v++) begin
                if (bc || id == 4'(v)) begin
                    model[v][a] = d0;
                    if (nd == 2) model[v][a1] = d1;
                end
            end
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int v = 0; v < 3; v++)
            for (int r = 0; r < 64; r++) model[v][r] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(soe == 3'b000, "R10", "miso_oe after reset", soe, 0);
        frame(4'd1, 0, 1, 1, 8'h05, 0, 0, 0, "R10 reset register value");
        // R3 R4: one write per chain position, then read each back
        frame(4'd0, 0, 0, 1, 8'h03, 8'hA5, 0, 0, "R3");
        frame(4'd1, 0, 0, 1, 8'h03, 8'h5A, 0, 0, "R3");
        frame(4'd2, 0, 0, 1, 8'h03, 8'h3C, 0, 0, "R3");
        for (int v = 0; v < 3; v++) frame(4'(v), 0, 1, 1, 8'h03, 0, 0, 0, "R3 R4 chain position read");
        // R3: ID past the chain end touches nothing
        frame(4'd5, 0, 0, 1, 8'h03, 8'hFF, 0, 0, "R3");
        for (int v = 0; v < 3; v++) frame(4'(v), 0, 1, 1, 8'h03, 0, 0, 0, "R3 ID beyond chain");
        // R6: upper address bits ignored
        frame(4'd2, 0, 0, 1, 8'hC7, 8'h77, 0, 0, "R6");
        frame(4'd2, 0, 1, 1, 8'h07, 0, 0, 0, "R6 address bits 7:6 ignored");
        // R5: broadcast write reaches all, broadcast read drives nothing
        frame(4'd1, 1, 0, 1, 8'h0A, 8'h99, 0, 0, "R5");
        for (int v = 0; v < 3; v++) frame(4'(v), 0, 1, 1, 8'h0A, 0, 0, 0, "R5 broadcast write");
        frame(4'd0, 1, 1, 1, 8'h0A, 0, 0, 0, "R5 broadcast read ignored");
        // R2: bad tag bits make the frame a no-op
        frame(4'd0, 0, 0, 0, 8'h03, 8'hEE, 0, 0, "R2");
        frame(4'd0, 0, 1, 1, 8'h03, 0, 0, 0, "R2 invalid write ignored");
        frame(4'd1, 0, 1, 0, 8'h03, 0, 0, 0, "R2 invalid read ignored");
        // R1 R6: two-byte mode with address wrap
        two_bytes = 1'b1;
        frame(4'd1, 0, 0, 1, 8'h3F, 8'h11, 8'h22, 0, "R6");
        frame(4'd1, 0, 1, 1, 8'h3F, 0, 0, 0, "R1 R6 two-byte read with wrap");
        two_bytes = 1'b0;
        frame(4'd1, 0, 1, 1, 8'h00, 0, 0, 0, "R6 wrapped second byte");
        frame(4'd1, 0, 1, 1, 8'h3F, 0, 0, 0, "R1 one-byte read");
        // R8: truncated control byte, then truncated data byte
        @(negedge clk); cs_n = 1'b0; repeat (H) @(negedge clk);
        send_bits(8'hA5, 5, 8'h00, d_cap, d_fe, d_oe, d_mu);
        @(negedge clk); cs_n = 1'b1; repeat (2 * H) @(negedge clk);
        frame(4'd0, 0, 0, 1, 8'h04, 8'h44, 0, 0, "R8");
        frame(4'd0, 0, 1, 1, 8'h04, 0, 0, 0, "R8 frame after partial control byte");
        @(negedge clk); cs_n = 1'b0; repeat (H) @(negedge clk);
        send_bits(8'h02, 8, 8'h00, d_cap, d_fe, d_oe, d_mu);
        send_bits(8'h04, 8, 8'h00, d_cap, d_fe, d_oe, d_mu);
        send_bits(8'hEE, 6, 8'h00, d_cap, d_fe, d_oe, d_mu);
        @(negedge clk); cs_n = 1'b1; repeat (2 * H) @(negedge clk);
        frame(4'd0, 0, 1, 1, 8'h04, 0, 0, 0, "R8 truncated data byte not written");
        // R9: select high between bytes with a running serial clock
        frame(4'd2, 0, 0, 1, 8'h14, 8'hC3, 0, 1, "R9");
        frame(4'd2, 0, 1, 1, 8'h14, 0, 0, 1, "R9 gapped read");
        frame(4'd1, 0, 1, 1, 8'h14, 0, 0, 0, "R9 gapped write only hit device 2");
        repeat (4 * H) @(negedge clk);
        check(exp_val.size() == 0, "R7", "pending read bytes", exp_val.size(), 0);
        summary();
        $finish;
    end
endmodule